// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs the external bus cycles of a CPU with a 24-bit word address. The CPU raises a request with an address, a direction and (for writes) data, and holds it until the block acknowledges. For every bus cycle the block decides when it completes. It combines a programmable wait counter with an external ready pin, and two bits of a small bus-control word choose how the two are combined.

Reads go to the bus directly. When bank comparison is on, a read whose bank differs from that of the last completed access is preceded by one dead cycle, so slow devices can release the bus. Writes are posted into a one-entry buffer. The CPU is acknowledged at once and the write drains onto the bus afterwards. A later access waits while the buffer holds a write. Four page strobes, decoded from the two top address bits, follow the bus strobe exactly.

Top module: `extBusCtl`

## Requirements
- R1: With ready-select 00 the bus cycle ends at the first strobe cycle where `extRdy` is high, and the wait count has no effect. The strobe length is (first ready cycle index)+1.
- R2: With ready-select 01 the strobe lasts exactly wait-count+1 cycles, whatever `extRdy` does.
- R3: With ready-select 10 the cycle ends at the first strobe cycle where the counter has expired and `extRdy` is high, so the length is max(W,R)+1.
- R4: With ready-select 11 the cycle ends at the first strobe cycle where either condition holds, so the length is min(W,R)+1. After reset the ready-select is 11, the wait count is all ones and bank comparison is off.
- R5: A pulse on `cfgWe` loads `cfgData`. Bits [4:3] are the ready-select, bits [8:5] the wait count W, bits [13:9] the number N of top address bits that form the bank, and bits [2:0] are unused. N=0 turns bank comparison off.
- R6: A read whose top N address bits differ from those of the last completed bus access (address 0 after reset) raises its strobe two cycles after the request instead of one, with the strobe low in between.
- R7: A write is never preceded by a dead cycle, even when its bank differs.
- R8: A write is acknowledged on the cycle after it is presented, before any bus strobe. The bus write follows with the buffered address and data.
- R9: While a posted write is pending, a second write is not acknowledged and a read is not started. Bus cycles occur in request order.
- R10: `pageStrb[i]` is high exactly while `busStrb` is high and `busAddr[23:22]` equals i. Otherwise all four are low.
- R11: Read data is captured from `busRdata` on the completing edge. `cpuAck` is a one-cycle pulse in the cycle after completion.
- R12: During and just after reset, `busStrb`, `cpuAck` and `pageStrb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; ready is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for the bus-control word |
| cfgData | input | 14 | Bus-control word: ready-select, wait count, bank bit count |
| cpuReq | input | 1 | CPU access request, held until acknowledged |
| cpuRd | input | 1 | 1 for read, 0 for write |
| cpuAddr | input | 24 | CPU access address |
| cpuWdata | input | 32 | CPU write data |
| cpuAck | output | 1 | One-cycle acknowledge of the current request |
| cpuRdata | output | 32 | Data of the last completed read |
| busStrb | output | 1 | Bus strobe, high during an active bus cycle |
| pageStrb | output | 4 | Page strobes decoded from the two top address bits |
| busAddr | output | 24 | Bus address |
| busWdata | output | 32 | Bus write data |
| busRnw | output | 1 | 1 for a read cycle, 0 for a write cycle |
| busRdata | input | 32 | Data returned by the external device |
| extRdy | input | 1 | External ready, active high |

## Verification
The assertions assume that the CPU keeps its request, direction, address and data steady from the moment it raises the request until the acknowledge arrives. They also assume that the bus-control word is rewritten only while no bus cycle is in flight. The bench drives every input on the falling clock edge, holds each request until the acknowledge is seen, and writes the control word only between accesses, after the bus has gone quiet. `extRdy` is driven as a function of the strobe cycle index, so each ready-select mode is swept against every combination of wait count and ready delay in a small range.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NULL = 2'd1,
    ST_ACT  = 2'd2
  } busSt_t;

  // ready-select encodings (cfg bits [4:3])
  localparam logic [1:0] RDY_EXT = 2'b00;
  localparam logic [1:0] RDY_CNT = 2'b01;
  localparam logic [1:0] RDY_AND = 2'b10;
  localparam logic [1:0] RDY_OR  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic takeWr;   // capture CPU write into the posted buffer
    logic loadRd;   // current cycle address from CPU
    logic loadWr;   // current cycle address/data from posted buffer
    logic loadCnt;  // load wait counter
    logic tick;     // count one active cycle
    logic finRd;    // capture read data
    logic finish;   // cycle complete, remember its bank
  } busCtl_t;

endpackage

// File: rtl/extBusCtl_ctrl.sv
module extBusCtl_ctrl
  import extbus_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BSEL_W = 5,
  localparam int CFG_W = 5 + WAIT_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              cpuReq,
  input  logic              cpuRd,
  input  logic              extRdy,
  input  logic              cntDone,
  input  logic              bankDiff,
  output busCtl_t           ctl,
  output logic [WAIT_W-1:0] cfgWait,
  output logic [BSEL_W-1:0] cfgBank,
  output logic              busStrb,
  output logic              busRnw,
  output logic              cpuAck
);

  busSt_t     state, nextState;
  logic [1:0] rdyMode;
  logic       wbValid;
  logic       ackQ;
  logic       rnwQ;
  logic       rdyMux;

  always_comb begin
    unique case (rdyMode)
      RDY_EXT: rdyMux = extRdy;
      RDY_CNT: rdyMux = cntDone;
      RDY_AND: rdyMux = cntDone & extRdy;
      default: rdyMux = cntDone | extRdy;
    endcase
  end

  always_comb begin
    ctl        = '0;
    nextState  = state;
    ctl.takeWr = cpuReq && !cpuRd && !wbValid && !ackQ;
    unique case (state)
      ST_IDLE: begin
        if (wbValid) begin
          ctl.loadWr  = 1'b1;
          ctl.loadCnt = 1'b1;
          nextState   = ST_ACT;
        end else if (cpuReq && cpuRd && !ackQ) begin
          ctl.loadRd = 1'b1;
          if (bankDiff) begin
            nextState = ST_NULL;
          end else begin
            ctl.loadCnt = 1'b1;
            nextState   = ST_ACT;
          end
        end
      end
      ST_NULL: begin
        ctl.loadCnt = 1'b1;
        nextState   = ST_ACT;
      end
      default: begin
        ctl.tick = 1'b1;
        if (rdyMux) begin
          ctl.finish = 1'b1;
          ctl.finRd  = rnwQ;
          nextState  = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wbValid <= 1'b0;
      ackQ    <= 1'b0;
      rnwQ    <= 1'b1;
      rdyMode <= RDY_OR;
      cfgWait <= '1;
      cfgBank <= '0;
    end else begin
      state <= nextState;
      ackQ  <= ctl.takeWr || (ctl.finish && rnwQ);
      if (ctl.takeWr) wbValid <= 1'b1;
      else if (ctl.finish && !rnwQ) wbValid <= 1'b0;
      if (ctl.loadRd) rnwQ <= 1'b1;
      else if (ctl.loadWr) rnwQ <= 1'b0;
      if (cfgWe) begin
        rdyMode <= cfgData[4:3];
        cfgWait <= cfgData[5 +: WAIT_W];
        cfgBank <= cfgData[5+WAIT_W +: BSEL_W];
      end
    end
  end

  assign busStrb = (state == ST_ACT);
  assign busRnw  = rnwQ;
  assign cpuAck  = ackQ;

  // R1: pin-only mode waits for the pin
  a_r1_ext_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && rdyMode == RDY_EXT && !extRdy) |=> state == ST_ACT);
  // R2: counter-only mode waits for the counter
  a_r2_cnt_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && rdyMode == RDY_CNT && !cntDone) |=> state == ST_ACT);
  // R3: AND mode needs the counter to expire
  a_r3_and_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && rdyMode == RDY_AND && !cntDone) |=> state == ST_ACT);
  // R6: a dead cycle is always followed by a read strobe
  a_r6_null_then_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NULL) |=> (state == ST_ACT && busRnw));
  // R8: the posted buffer is never overwritten
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeWr |-> !wbValid);
  // R9: no read on the bus while a write is pending
  a_r9_read_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACT && busRnw) |-> !wbValid);
  // R11: acknowledge is a single-cycle pulse
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);

endmodule

// File: rtl/extBusCtl_dp.sv
module extBusCtl_dp
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int BSEL_W = 5,
  parameter int PAGES  = 4,
  localparam int PSEL_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic [BSEL_W-1:0] cfgBank,
  input  logic              strbOn,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [PAGES-1:0]  pageStrb,
  output logic              cntDone,
  output logic              bankDiff
);

  logic [ADDR_W-1:0] wbAddr, lastAddr, bankMask;
  logic [DATA_W-1:0] wbData;
  logic [WAIT_W-1:0] waitCnt;

  assign bankMask = ~({ADDR_W{1'b1}} >> cfgBank);
  assign bankDiff = |((cpuAddr ^ lastAddr) & bankMask);
  assign cntDone  = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAddr   <= '0;
      wbData   <= '0;
      busAddr  <= '0;
      busWdata <= '0;
      cpuRdata <= '0;
      lastAddr <= '0;
      waitCnt  <= '0;
    end else begin
      if (ctl.takeWr) begin
        wbAddr <= cpuAddr;
        wbData <= cpuWdata;
      end
      if (ctl.loadRd) busAddr <= cpuAddr;
      else if (ctl.loadWr) begin
        busAddr  <= wbAddr;
        busWdata <= wbData;
      end
      if (ctl.loadCnt) waitCnt <= cfgWait;
      else if (ctl.tick && !cntDone) waitCnt <= waitCnt - 1'b1;
      if (ctl.finRd) cpuRdata <= busRdata;
      if (ctl.finish) lastAddr <= busAddr;
    end
  end

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    assign pageStrb[p] = strbOn && (busAddr[ADDR_W-1 -: PSEL_W] == PSEL_W'(p));
  end

  // R10: never more than one page strobe
  a_r10_page_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pageStrb));
  // R11: read data changes only on a completing read
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finRd |=> $stable(cpuRdata));

endmodule

// File: rtl/extBusCtl.sv
module extBusCtl
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  localparam int BSEL_W = $clog2(ADDR_W + 1),
  localparam int CFG_W  = 5 + WAIT_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              cpuReq,
  input  logic              cpuRd,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busStrb,
  output logic [3:0]        pageStrb,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busRnw,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              extRdy
);

  busCtl_t           ctl;
  logic [WAIT_W-1:0] cfgWait;
  logic [BSEL_W-1:0] cfgBank;
  logic              cntDone, bankDiff;

  extBusCtl_ctrl #(.WAIT_W(WAIT_W), .BSEL_W(BSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .cpuReq(cpuReq), .cpuRd(cpuRd), .extRdy(extRdy),
    .cntDone(cntDone), .bankDiff(bankDiff), .ctl(ctl),
    .cfgWait(cfgWait), .cfgBank(cfgBank),
    .busStrb(busStrb), .busRnw(busRnw), .cpuAck(cpuAck)
  );

  extBusCtl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
                 .BSEL_W(BSEL_W), .PAGES(4)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cfgWait(cfgWait), .cfgBank(cfgBank),
    .strbOn(busStrb), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .cpuRdata(cpuRdata), .pageStrb(pageStrb),
    .cntDone(cntDone), .bankDiff(bankDiff)
  );

endmodule

// File: tb/sim_extBusCtl.sv
module sim_extBusCtl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [13:0] cfgData = '0;
  logic        cpuReq = 1'b0, cpuRd = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuAck, busStrb, busRnw;
  logic [31:0] cpuRdata, busWdata, busRdata;
  logic [3:0]  pageStrb;
  logic [23:0] busAddr;
  logic        extRdy = 1'b0;

  int tests = 0, fails = 0, cycles = 0;
  int rdyAt = 0, k = 0, lastLen = 0, logN = 0;
  logic        logRnw  [16];
  logic [23:0] logAddr [16];
  logic [31:0] logData [16];

  always #10 clk = ~clk;

  assign busRdata = {8'hA5, busAddr};

  extBusCtl u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .cpuReq(cpuReq), .cpuRd(cpuRd), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuAck(cpuAck), .cpuRdata(cpuRdata), .busStrb(busStrb),
    .pageStrb(pageStrb), .busAddr(busAddr), .busWdata(busWdata),
    .busRnw(busRnw), .busRdata(busRdata), .extRdy(extRdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor: drives extRdy per strobe cycle, logs cycles, checks pages
  always @(negedge clk) begin
    if (busStrb) begin
      if (k == 0) begin
        if (logN < 16) begin
          logRnw[logN]  = busRnw;
          logAddr[logN] = busAddr;
          logData[logN] = busWdata;
        end
        logN++;
        chk(pageStrb == (4'b1 << busAddr[23:22]), "R10 page strobe", 64'(pageStrb),
            64'(4'b1 << busAddr[23:22]));
      end
      extRdy = (k >= rdyAt);
      k++;
    end else begin
      if (k != 0) lastLen = k;
      k = 0;
      extRdy = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input int mode, input int w, input int bank);
    cfgData = {5'(bank), 4'(w), 2'(mode), 3'b000};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // present a request, wait for ack; lat = negedges until first strobe, ackAt = negedges until ack
  task automatic doAccess(input bit rd, input logic [23:0] a, input logic [31:0] d,
                          output int lat, output int ackAt, output logic [31:0] rdat);
    int n = 0;
    lat = 0;
    cpuReq = 1'b1; cpuRd = rd; cpuAddr = a; cpuWdata = d;
    forever begin
      @(negedge clk);
      n++;
      if (busStrb && lat == 0) lat = n;
      if (cpuAck || n > 300) break;
    end
    ackAt = n;
    rdat = cpuRdata;
    cpuReq = 1'b0;
  endtask

  task automatic strbDelay(output int n);
    n = 0;
    while (!busStrb && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int expLen(input int m, input int w, input int r);
    case (m)
      0: return r + 1;
      1: return w + 1;
      2: return ((w > r) ? w : r) + 1;
      default: return ((w < r) ? w : r) + 1;
    endcase
  endfunction

  initial begin
    int lat, ackAt, dly;
    logic [31:0] rd;
    logic [23:0] a;

    // R12: reset state
    repeat (3) @(negedge clk);
    chk(!busStrb && !cpuAck && pageStrb == 0, "R12 reset outputs",
        64'({busStrb, cpuAck, pageStrb}), 64'd0);
    rstN = 1'b1;
    idle(2);
    chk(!busStrb && !cpuAck && pageStrb == 0, "R12 after reset idle",
        64'({busStrb, cpuAck, pageStrb}), 64'd0);

    // R4: reset default is OR with wait 15
    rdyAt = 2;
    doAccess(1'b1, 24'h0000A0, 0, lat, ackAt, rd);
    idle(3);
    chk(lastLen == 3, "R4 default OR mode pin early", 64'(lastLen), 64'd3);
    chk(lat == 1, "R4 default bank compare off", 64'(lat), 64'd1);
    rdyAt = 1000;
    doAccess(1'b1, 24'hC00001, 0, lat, ackAt, rd);
    idle(3);
    chk(lastLen == 16, "R4 default wait count 15", 64'(lastLen), 64'd16);
    chk(lat == 1, "R4 default bank compare off across banks", 64'(lat), 64'd1);

    // R1..R5, R11: sweep ready-select x wait x ready delay on reads
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
        for (int r = 0; r < 5; r++) begin
          setCfg(m, w, 0);
          rdyAt = r;
          a = {2'(m), 6'(w), 8'(r), 8'h5A};
          doAccess(1'b1, a, 0, lat, ackAt, rd);
          idle(3);
          chk(lastLen == expLen(m, w, r),
              (m == 0) ? "R1 R5 ext-only length" : (m == 1) ? "R2 R5 counter-only length" :
              (m == 2) ? "R3 R5 AND length" : "R4 R5 OR length",
              64'(lastLen), 64'(expLen(m, w, r)));
          chk(rd == {8'hA5, a}, "R11 read data", 64'(rd), 64'({8'hA5, a}));
          chk(ackAt == lat + expLen(m, w, r), "R11 ack follows completion",
              64'(ackAt), 64'(lat + expLen(m, w, r)));
        end

    // R8: posted writes with counter-only timing
    for (int w = 0; w < 4; w++) begin
      setCfg(1, w, 0);
      rdyAt = 1000;
      logN = 0;
      a = {2'(w), 22'h1234 + 22'(w)};
      doAccess(1'b0, a, 32'hBEEF0000 + w, lat, ackAt, rd);
      chk(ackAt == 1 && lat == 0, "R8 write acked before strobe", 64'(ackAt), 64'd1);
      strbDelay(dly);
      chk(dly == 1, "R8 write strobe follows ack", 64'(dly), 64'd1);
      idle(w + 4);
      chk(lastLen == w + 1, "R8 write length", 64'(lastLen), 64'(w + 1));
      chk(logN == 1 && !logRnw[0] && logAddr[0] == a && logData[0] == 32'hBEEF0000 + w,
          "R8 write address and data", 64'(logData[0]), 64'(32'hBEEF0000 + w));
    end

    // R9: write, write, read back to back
    setCfg(1, 3, 0);
    logN = 0;
    doAccess(1'b0, 24'h100010, 32'h11111111, lat, ackAt, rd);
    doAccess(1'b0, 24'h200020, 32'h22222222, lat, ackAt, rd);
    chk(ackAt >= 5, "R9 second write waits for drain", 64'(ackAt), 64'd5);
    doAccess(1'b1, 24'h300030, 0, lat, ackAt, rd);
    idle(8);
    chk(logN == 3, "R9 bus cycle count", 64'(logN), 64'd3);
    chk(!logRnw[0] && logAddr[0] == 24'h100010 && logData[0] == 32'h11111111,
        "R9 first write first", 64'(logAddr[0]), 64'h100010);
    chk(!logRnw[1] && logAddr[1] == 24'h200020 && logData[1] == 32'h22222222,
        "R9 second write second", 64'(logAddr[1]), 64'h200020);
    chk(logRnw[2] && logAddr[2] == 24'h300030, "R9 read after writes", 64'(logAddr[2]), 64'h300030);
    chk(rd == 32'hA5300030, "R9 read data", 64'(rd), 64'hA5300030);

    // R6, R7: bank compare on top 2 bits; last access was 0x300030 (bank 0)
    setCfg(1, 1, 2);
    doAccess(1'b1, 24'h000010, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 1, "R6 same bank no dead cycle", 64'(lat), 64'd1);
    doAccess(1'b1, 24'h400000, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 2, "R6 new bank dead cycle", 64'(lat), 64'd2);
    chk(rd == 32'hA5400000, "R6 read data after dead cycle", 64'(rd), 64'hA5400000);
    doAccess(1'b1, 24'h400100, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 1, "R6 repeat bank no dead cycle", 64'(lat), 64'd1);
    doAccess(1'b0, 24'h800000, 32'h5A5A5A5A, lat, ackAt, rd);
    strbDelay(dly);
    chk(dly == 1, "R7 write to new bank not delayed", 64'(dly), 64'd1);
    idle(4);
    doAccess(1'b1, 24'h800004, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 1, "R6 bank taken from last write", 64'(lat), 64'd1);
    doAccess(1'b1, 24'hC00000, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 2, "R6 third bank dead cycle", 64'(lat), 64'd2);
    setCfg(1, 1, 0);
    doAccess(1'b1, 24'h000000, 0, lat, ackAt, rd);
    idle(3);
    chk(lat == 1, "R5 R6 zero bank bits disables compare", 64'(lat), 64'd1);

    idle(2);
    chk(!busStrb && !cpuAck && pageStrb == 0, "R10 quiet bus no page strobe",
        64'({busStrb, cpuAck, pageStrb}), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule